// File: doc/BRIEF.md
# Full-Period Shift-Register Counter

This block is a right-shifting, many-to-one XOR feedback shift register. It steps through every one of the 2^W values of its W-bit state, the all-zeros value included. A plain XOR shift register of this kind skips all zeros and would stay stuck there if it ever reached it. Here a detector watches bits W-1 down to 1. When all of them are zero, its output is XORed into the feedback. This does two things: the value with only bit 0 set steps into all zeros, and all zeros steps on to the value with only the top bit set. The counter therefore has no lockup state.

On each enabled clock the state moves one place toward bit 0, and the new feedback bit enters at the top. The block is used as a compact counter with a full period, or as a pattern and pseudo-random source. The whole state is available in parallel, and bit 0 doubles as the serial output. It is a free-running source with no data input, so both outputs are plain level signals with no handshake. The widths with tap sets are 3, 4, 5, 6, 7, 8 and 16.

Top module: `fpl_counter`

## Requirements
- R1: While `rst_n` is low, the state is all ones, and it stays all ones at the first clock edge after `rst_n` goes high.
- R2: On each clock with `en` high, the new `state[W-2:0]` equals the previous `state[W-1:1]`, so the register shifts toward bit 0.
- R3: The new `state[W-1]` is the XOR of the tap bits and the escape term. The tap bits are 0 and 1 for W=4; 0, 2, 3 and 4 for W=8; 0, 1, 3 and 12 for W=16.
- R4: With `en` high, a state with only bit 0 set steps to all zeros.
- R5: With `en` high, the all-zeros state steps to a state with only bit W-1 set.
- R6: Over 2^W consecutive enabled steps, every W-bit value appears exactly once, and the state then returns to its starting value.
- R7: On a clock with `en` low, the state does not change.
- R8: `ser` always equals `state[0]`.
- R9: For W=4, starting from reset, the enabled sequence is 1111, 0111, 0011, 0001, 0000, 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, and then back to 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst_n | input | 1 | Active-low reset that sets the state to all ones |
| en | input | 1 | Step enable; the state holds while low |
| state | output | W | Parallel counter state |
| ser | output | 1 | Serial output bit, equal to state bit 0 |

## Verification
On every cycle, assertions check the shift toward bit 0, the hold while disabled, the two escape transitions around all zeros, and the reset value. Only the bench scenarios can show the full-period property and the exact tap positions. To do that, the bench runs a model of each width under random enable patterns and counts how many times each of the 2^W values is visited in one period. A directed run of the 4-bit width checks the exact order of its sequence.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  // Tap positions in right-shift orientation: bit 0 always feeds back.
  function automatic logic [63:0] tap_mask(input int w);
    logic [63:0] m;
    case (w)
      3, 4, 6, 7: m = 64'h3;
      5:          m = 64'h5;
      8:          m = 64'h1D;
      16:         m = 64'h100B;
      default:    m = 64'h3;
    endcase
    return m;
  endfunction

  function automatic int tap_count(input int w);
    logic [63:0] m;
    int n;
    m = tap_mask(w);
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(m[i]);
    return n;
  endfunction

  // Position of the tap other than bit 0, for two-tap widths.
  function automatic int upper_tap(input int w);
    logic [63:0] m;
    int p;
    m = tap_mask(w);
    p = 1;
    for (int i = 63; i > 0; i--) if (m[i]) p = i;
    return p;
  endfunction

endpackage

// File: rtl/fpl_taps.sv
module fpl_taps #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  output logic         lin_fb
);
  localparam int          NTAPS = fpl_pkg::tap_count(W);
  localparam logic [63:0] MASK  = fpl_pkg::tap_mask(W);
  localparam logic [W-1:0] WMASK = MASK[W-1:0];

  generate
    if (NTAPS == 2) begin : g_pair
      localparam int HI = fpl_pkg::upper_tap(W);
      assign lin_fb = cur[0] ^ cur[HI];
    end else begin : g_tree
      assign lin_fb = ^(cur & WMASK);
    end
  endgenerate
endmodule

// File: rtl/fpl_escape.sv
module fpl_escape #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  output logic         upper_clear
);
  // NOR of every bit except bit 0.
  assign upper_clear = ~|cur[W-1:1];
endmodule

// File: rtl/fpl_shreg.sv
module fpl_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fb_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '1;
    else if (en) q <= {fb_in, q[W-1:1]};
  end

  // R7: hold while disabled
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
  // R2: shift toward bit 0
  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q[W-2:0] == $past(q[W-1:1]));
endmodule

// File: rtl/fpl_counter.sv
module fpl_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] state,
  output logic         ser
);
  localparam logic [W-1:0] ONLY_LSB = W'(1);
  localparam logic [W-1:0] ONLY_MSB = ONLY_LSB << (W - 1);

  logic lin_fb;
  logic upper_clear;
  logic fb;

  fpl_taps #(.W(W)) u_taps (
    .cur    (state),
    .lin_fb (lin_fb)
  );

  fpl_escape #(.W(W)) u_esc (
    .cur         (state),
    .upper_clear (upper_clear)
  );

  assign fb = lin_fb ^ upper_clear;

  fpl_shreg #(.W(W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .fb_in (fb),
    .q     (state)
  );

  assign ser = state[0];

  // R1: state still all ones at first edge after reset release
  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> state == '1);
  // R4: escape into all zeros
  a_r4_enter_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ONLY_LSB) |=> state == '0);
  // R5: leave all zeros to top bit only
  a_r5_leave_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == '0) |=> state == ONLY_MSB);
endmodule

// File: tb/fpl_counter_test.sv
module fpl_counter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0]  st4;
  logic [7:0]  st8;
  logic [15:0] st16;
  logic ser4, ser8, ser16;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpl_counter #(.W(4))  uut   (.clk(clk), .rst_n(rst_n), .en(en), .state(st4),  .ser(ser4));
  fpl_counter #(.W(8))  uut8  (.clk(clk), .rst_n(rst_n), .en(en), .state(st8),  .ser(ser8));
  fpl_counter #(.W(16)) uut16 (.clk(clk), .rst_n(rst_n), .en(en), .state(st16), .ser(ser16));

  // Independent model of one enabled step.
  function automatic logic [15:0] step(input int w, input logic [15:0] s, input logic [15:0] taps);
    logic [15:0] wm, sm, nx;
    logic f;
    wm = (w == 16) ? 16'hFFFF : ((16'h1 << w) - 16'h1);
    sm = s & wm;
    f = (^(sm & taps)) ^ ((sm >> 1) == 16'h0);
    nx = (sm >> 1) | ({15'h0, f} << (w - 1));
    return nx & wm;
  endfunction

  function automatic logic [3:0] seq4(input int i);
    case (i)
      0: return 4'b1111;  1: return 4'b0111;  2: return 4'b0011;  3: return 4'b0001;
      4: return 4'b0000;  5: return 4'b1000;  6: return 4'b0100;  7: return 4'b0010;
      8: return 4'b1001;  9: return 4'b1100; 10: return 4'b0110; 11: return 4'b1011;
      12: return 4'b0101; 13: return 4'b1010; 14: return 4'b1101; default: return 4'b1110;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] m4, m8, m16;
  int vis4 [16];
  int vis8 [256];
  byte vis16 [65536];
  int n4, n8, n16;

  task automatic compare_all(input string req);
    chk(st4 == m4[3:0], req, {12'h0, st4}, m4);
    chk(st8 == m8[7:0], req, {8'h0, st8}, m8);
    chk(st16 == m16, req, st16, m16);
    chk(ser4 == st4[0] && ser8 == st8[0] && ser16 == st16[0], "R8 serial bit",
        {13'h0, ser4, ser8, ser16}, {13'h0, st4[0], st8[0], st16[0]});
  endtask

  task automatic advance_models();
    m4  = step(4,  m4,  16'h0003);
    m8  = step(8,  m8,  16'h001D);
    m16 = step(16, m16, 16'h100B);
    if (n4 < 16)     begin vis4[m4[3:0]]++;  n4++;  end
    if (n8 < 256)    begin vis8[m8[7:0]]++;  n8++;  end
    if (n16 < 65536) begin vis16[m16] = byte'(vis16[m16] + 1); n16++; end
  endtask

  initial begin
    void'($urandom(32'd1234));
    m4 = 16'hF; m8 = 16'hFF; m16 = 16'hFFFF;
    n4 = 0; n8 = 0; n16 = 0;
    for (int i = 0; i < 16; i++) vis4[i] = 0;
    for (int i = 0; i < 256; i++) vis8[i] = 0;
    for (int i = 0; i < 65536; i++) vis16[i] = 0;

    // R1: reset state
    #(CLK_PERIOD*3 + 2);
    chk(st4 == 4'hF && st8 == 8'hFF && st16 == 16'hFFFF, "R1 reset all ones",
        {st4, st8, st16[3:0]}, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st4 == 4'hF, "R1 held after release", {12'h0, st4}, 16'hF);

    // R9 with R4 and R5: directed 4-bit order from reset
    en = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      advance_models();
      @(negedge clk);
      chk(st4 == seq4(i % 16), "R9 4-bit order", {12'h0, st4}, {12'h0, seq4(i % 16)});
      if (i == 4) chk(st4 == 4'b0000, "R4 0001 to 0000", {12'h0, st4}, 16'h0);
      if (i == 5) chk(st4 == 4'b1000, "R5 0000 to 1000", {12'h0, st4}, 16'h8);
      compare_all("R3 taps R2 shift");
    end

    // R7: hold with enable low
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      compare_all("R7 hold");
    end

    // Random enable run covering a full 16-bit period
    while (n16 < 65536) begin
      logic [15:0] p4, p16;
      p4 = {12'h0, st4}; p16 = st16;
      en = ($urandom % 4) != 0;
      if (en) advance_models();
      @(negedge clk);
      compare_all("R3 taps R2 shift R7 hold");
      if (en) begin
        chk(st16[14:0] == p16[15:1], "R2 shift 16", {1'b0, st16[14:0]}, {1'b0, p16[15:1]});
        chk(st4[2:0] == p4[3:1], "R2 shift 4", {13'h0, st4[2:0]}, {13'h0, p4[3:1]});
      end
    end
    en = 1'b0;

    // R6: every value once per period
    for (int i = 0; i < 16; i++)
      chk(vis4[i] == 1, "R6 period W=4", 16'(vis4[i]), 16'h1);
    for (int i = 0; i < 256; i++)
      chk(vis8[i] == 1, "R6 period W=8", 16'(vis8[i]), 16'h1);
    begin
      int bad16;
      bad16 = 0;
      for (int i = 0; i < 65536; i++) if (vis16[i] != 1) bad16++;
      chk(bad16 == 0, "R6 period W=16", 16'(bad16), 16'h0);
    end

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk(st4 == 4'hF && st8 == 8'hFF && st16 == 16'hFFFF, "R1 mid-run reset",
        {st4, st8, st16[3:0]}, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule